// File: doc/BRIEF.md
# Security Violation Interrupt Aggregator

This block collects the level-sensitive violation status lines of a chip's security fabric into registers that software reads over a 32-bit register port. There are three source families: peripheral protection groups (two internal APB groups, four APB expansion groups and four AHB expansion groups), memory protection units (internal and expansion), and expansion master-security units. Each status line is captured into its own fixed bit position of a status word. Software reads the status words, sets enables, and issues clears. The block hands those enables and clears back to each source as individual control lines.

For the master-security sources the block also keeps an enable word and a non-secure selection word. It forms one combined level interrupt that is high whenever an enabled master-security status bit is set. Two small configuration words drive the violation response style and the non-secure-callable setting directly onto output pins. A bridge enable word is stored, but the bridge status always reads as zero. Writes are whole 32-bit words. Reads are combinational from the read address.

Register map (byte offsets on the 8-bit address): 0x00 response config, 0x04 callable config, 0x08 memory-protection status, 0x0C group status, 0x10 group clear, 0x14 group enable, 0x18 master status, 0x1C master clear, 0x20 master enable, 0x24 bridge status, 0x28 bridge clear, 0x2C bridge enable, 0x30 master non-secure. Any other offset reads zero and ignores writes.

Top module: `sec_irq_agg`

## Requirements
- R1: Group status input i lands in the group status word (0x0C) at a fixed bit: inputs 0..1 at bits 0..1, inputs 2..5 at bits 4..7, inputs 6..9 at bits 20..23. The bit follows its input one clock later.
- R2: A write to the group enable word (0x14) is masked with 0x00F000F3 and reads back masked. Output grp_irq_en[i] equals the enable bit at group i's position from R1, and it changes only after such a write.
- R3: A write to the group clear word (0x10) is masked with 0x00F000F3. grp_irq_clr[i] is high for exactly the one cycle after the write, when the written bit at group i's position is set. The clear word reads as zero.
- R4: The memory-protection status word (0x08) holds internal input n at bit n and expansion input n at bit 16+n, each one clock after its input. All other bits are zero.
- R5: The master status word (0x18) holds master input n at bit 16+n one clock after its input. The master enable word (0x20) keeps only bits [19:16].
- R6: msu_irq is registered. In each cycle it equals the OR over bits of (master status word AND master enable word) as those words stood in the cycle before.
- R7: A write to the master clear word (0x1C) pulses msu_clr[n] for one cycle from written bit 16+n. The word reads as zero.
- R8: The master non-secure word (0x30) keeps only bits [19:16] and drives msu_ns[n] from bit 16+n.
- R9: The response config word (0x00) keeps only bit 0 and drives resp_cfg. The callable config word (0x04) keeps bits [1:0] and drives call_cfg.
- R10: The bridge enable word (0x2C) keeps only bits [31:16]. Bridge status (0x24) and bridge clear (0x28) read as zero, and writes to them change nothing.
- R11: Writes to the status words (0x08, 0x0C, 0x18) and to unmapped offsets change nothing. Unmapped offsets read as zero.
- R12: Synchronous reset clears every stored word, every status word, all strobes and msu_irq, so every output and every readable word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| grp_status | input | 10 | Protection group violation levels |
| mpu_int_status | input | 1 | Internal memory-protection violation levels |
| mpu_exp_status | input | 16 | Expansion memory-protection violation levels |
| msu_status | input | 4 | Master-security unit violation levels |
| grp_irq_en | output | 10 | Per-group interrupt enable |
| grp_irq_clr | output | 10 | Per-group one-cycle clear strobe |
| msu_clr | output | 4 | Per-master one-cycle clear strobe |
| msu_ns | output | 4 | Per-master non-secure selection |
| msu_irq | output | 1 | Combined master-security interrupt |
| resp_cfg | output | 1 | Violation response style |
| call_cfg | output | 2 | Non-secure-callable configuration |

## Verification
A wrong bit position in the group mapping shows in the same cycle on two sides. It shows on the grp_irq_en or grp_irq_clr pin of the affected group, and on the readback of the enable or status word. A corrupted master status or enable word shows on msu_irq one cycle later, when the registered interrupt disagrees with the model. A clear strobe that is held too long or fires too often differs at the strobe pins in the cycle after the write. A mask bit that is stored but should have been dropped shows on the next read of that word.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;

    localparam int DW = 32;
    localparam int AW = 8;

    // protection group families and their fixed landing bits
    localparam int N_GRP_INT  = 2;
    localparam int N_GRP_APBX = 4;
    localparam int N_GRP_AHBX = 4;
    localparam int N_GRP      = N_GRP_INT + N_GRP_APBX + N_GRP_AHBX;
    localparam int APBX_LSB   = 4;
    localparam int AHBX_LSB   = 20;
    localparam int EXP_LSB    = 16;

    localparam logic [DW-1:0] BRG_EN_MASK = 32'hFFFF_0000;

    typedef enum logic [AW-1:0] {
        OFF_RESP     = 8'h00,
        OFF_CALL     = 8'h04,
        OFF_MPU_STAT = 8'h08,
        OFF_GRP_STAT = 8'h0C,
        OFF_GRP_CLR  = 8'h10,
        OFF_GRP_EN   = 8'h14,
        OFF_MSU_STAT = 8'h18,
        OFF_MSU_CLR  = 8'h1C,
        OFF_MSU_EN   = 8'h20,
        OFF_BRG_STAT = 8'h24,
        OFF_BRG_CLR  = 8'h28,
        OFF_BRG_EN   = 8'h2C,
        OFF_MSU_NS   = 8'h30
    } reg_off_e;

    typedef struct packed {
        logic [DW-1:0] grp;
        logic [DW-1:0] mpu;
        logic [DW-1:0] msu;
    } stat_t;

    typedef struct packed {
        logic          resp;
        logic [1:0]    call;
        logic [DW-1:0] grp_en;
        logic [DW-1:0] msu_en;
        logic [DW-1:0] msu_ns;
        logic [DW-1:0] brg_en;
    } ctl_t;

    // bit position of protection group idx inside the group words
    function automatic int grp_pos(input int idx);
        if (idx < N_GRP_INT)
            return idx;
        if (idx < N_GRP_INT + N_GRP_APBX)
            return APBX_LSB + idx - N_GRP_INT;
        return AHBX_LSB + idx - N_GRP_INT - N_GRP_APBX;
    endfunction

    function automatic logic [DW-1:0] grp_mask();
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < N_GRP; i++)
            m[grp_pos(i)] = 1'b1;
        return m;
    endfunction

    function automatic logic [DW-1:0] exp_mask(input int n);
        return DW'(((64'd1 << n) - 64'd1) << EXP_LSB);
    endfunction

endpackage

// File: rtl/sec_irq_regs.sv
module sec_irq_regs
    import sec_irq_pkg::*;
#(
    parameter int N_MSU = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output ctl_t          ctl_q,
    output logic [DW-1:0] grp_clr_q,
    output logic [DW-1:0] msu_clr_q
);
    localparam logic [DW-1:0] GRP_MASK = grp_mask();
    localparam logic [DW-1:0] MSU_MASK = exp_mask(N_MSU);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            grp_clr_q <= '0;
            msu_clr_q <= '0;
        end else begin
            grp_clr_q <= '0;
            msu_clr_q <= '0;
            if (wr_en) begin
                case (wr_addr)
                    OFF_RESP:    ctl_q.resp   <= wr_data[0];
                    OFF_CALL:    ctl_q.call   <= wr_data[1:0];
                    OFF_GRP_EN:  ctl_q.grp_en <= wr_data & GRP_MASK;
                    OFF_GRP_CLR: grp_clr_q    <= wr_data & GRP_MASK;
                    OFF_MSU_EN:  ctl_q.msu_en <= wr_data & MSU_MASK;
                    OFF_MSU_CLR: msu_clr_q    <= wr_data & MSU_MASK;
                    OFF_MSU_NS:  ctl_q.msu_ns <= wr_data & MSU_MASK;
                    OFF_BRG_EN:  ctl_q.brg_en <= wr_data & BRG_EN_MASK;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sec_irq_status.sv
module sec_irq_status
    import sec_irq_pkg::*;
#(
    parameter int N_MPU_INT = 1,
    parameter int N_MPU_EXP = 16,
    parameter int N_MSU     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_GRP-1:0]     grp_status,
    input  logic [N_MPU_INT-1:0] mpu_int_status,
    input  logic [N_MPU_EXP-1:0] mpu_exp_status,
    input  logic [N_MSU-1:0]     msu_status,
    output stat_t                stat_q
);
    stat_t nxt;

    always_comb begin
        nxt = '0;
        for (int i = 0; i < N_GRP; i++)
            nxt.grp[grp_pos(i)] = grp_status[i];
        nxt.mpu[N_MPU_INT-1:0]         = mpu_int_status;
        nxt.mpu[EXP_LSB +: N_MPU_EXP]  = mpu_exp_status;
        nxt.msu[EXP_LSB +: N_MSU]      = msu_status;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= nxt;
    end
endmodule

// File: rtl/sec_irq_combine.sv
module sec_irq_combine
    import sec_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] msu_stat,
    input  logic [DW-1:0] msu_en,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(msu_stat & msu_en);
    end
endmodule

// File: rtl/sec_irq_rdmux.sv
module sec_irq_rdmux
    import sec_irq_pkg::*;
(
    input  logic [AW-1:0] rd_addr,
    input  ctl_t          ctl,
    input  stat_t         stat,
    output logic [DW-1:0] rd_data
);
    always_comb begin
        case (rd_addr)
            OFF_RESP:     rd_data = {{(DW-1){1'b0}}, ctl.resp};
            OFF_CALL:     rd_data = {{(DW-2){1'b0}}, ctl.call};
            OFF_MPU_STAT: rd_data = stat.mpu;
            OFF_GRP_STAT: rd_data = stat.grp;
            OFF_GRP_EN:   rd_data = ctl.grp_en;
            OFF_MSU_STAT: rd_data = stat.msu;
            OFF_MSU_EN:   rd_data = ctl.msu_en;
            OFF_MSU_NS:   rd_data = ctl.msu_ns;
            OFF_BRG_EN:   rd_data = ctl.brg_en;
            default:      rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sec_irq_agg.sv
module sec_irq_agg
    import sec_irq_pkg::*;
#(
    parameter int N_MPU_INT = 1,
    parameter int N_MPU_EXP = 16,
    parameter int N_MSU     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic [DW-1:0]        rd_data,
    input  logic [N_GRP-1:0]     grp_status,
    input  logic [N_MPU_INT-1:0] mpu_int_status,
    input  logic [N_MPU_EXP-1:0] mpu_exp_status,
    input  logic [N_MSU-1:0]     msu_status,
    output logic [N_GRP-1:0]     grp_irq_en,
    output logic [N_GRP-1:0]     grp_irq_clr,
    output logic [N_MSU-1:0]     msu_clr,
    output logic [N_MSU-1:0]     msu_ns,
    output logic                 msu_irq,
    output logic                 resp_cfg,
    output logic [1:0]           call_cfg
);
    ctl_t          ctl_q;
    stat_t         stat_q;
    logic [DW-1:0] grp_clr_q;
    logic [DW-1:0] msu_clr_q;
    logic [DW-1:0] msu_stat_w;
    logic [DW-1:0] msu_en_w;

    sec_irq_regs #(.N_MSU(N_MSU)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ctl_q     (ctl_q),
        .grp_clr_q (grp_clr_q),
        .msu_clr_q (msu_clr_q)
    );

    sec_irq_status #(
        .N_MPU_INT (N_MPU_INT),
        .N_MPU_EXP (N_MPU_EXP),
        .N_MSU     (N_MSU)
    ) u_stat (
        .clk            (clk),
        .rst            (rst),
        .grp_status     (grp_status),
        .mpu_int_status (mpu_int_status),
        .mpu_exp_status (mpu_exp_status),
        .msu_status     (msu_status),
        .stat_q         (stat_q)
    );

    assign msu_stat_w = stat_q.msu;
    assign msu_en_w   = ctl_q.msu_en;

    sec_irq_combine u_comb (
        .clk      (clk),
        .rst      (rst),
        .msu_stat (msu_stat_w),
        .msu_en   (msu_en_w),
        .irq      (msu_irq)
    );

    sec_irq_rdmux u_rd (
        .rd_addr (rd_addr),
        .ctl     (ctl_q),
        .stat    (stat_q),
        .rd_data (rd_data)
    );

    // hand enables and strobes back to each source from its own bit
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign grp_irq_en[g]  = ctl_q.grp_en[grp_pos(g)];
        assign grp_irq_clr[g] = grp_clr_q[grp_pos(g)];
    end

    for (genvar m = 0; m < N_MSU; m++) begin : g_msu
        assign msu_clr[m] = msu_clr_q[EXP_LSB + m];
        assign msu_ns[m]  = ctl_q.msu_ns[EXP_LSB + m];
    end

    // strobe bits outside the source positions are always zero
    logic unused_strobe_bits;
    assign unused_strobe_bits = ^{grp_clr_q, msu_clr_q};

    assign resp_cfg = ctl_q.resp;
    assign call_cfg = ctl_q.call;
endmodule

// File: rtl/sec_irq_agg_chk.sv
module sec_irq_agg_chk
    import sec_irq_pkg::*;
#(
    parameter int N_MSU = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [N_GRP-1:0] grp_irq_en,
    input logic [N_GRP-1:0] grp_irq_clr,
    input logic [N_MSU-1:0] msu_clr,
    input logic             msu_irq,
    input logic             resp_cfg,
    input logic [1:0]       call_cfg,
    input logic [DW-1:0]    msu_stat_w,
    input logic [DW-1:0]    msu_en_w
);
    logic past_valid = 1'b0;
    logic rst_d      = 1'b0;

    always_ff @(posedge clk) begin
        rst_d      <= rst;
        past_valid <= !rst;
    end

    AST_GRP_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst || !past_valid)
        (grp_irq_clr != '0) |-> $past(wr_en && wr_addr == OFF_GRP_CLR)); // R3

    AST_GRP_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst || !past_valid)
        ((grp_irq_clr != '0) && !(wr_en && wr_addr == OFF_GRP_CLR)) |=> (grp_irq_clr == '0)); // R3

    AST_MSU_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst || !past_valid)
        (msu_clr != '0) |-> $past(wr_en && wr_addr == OFF_MSU_CLR)); // R7

    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (rst || !past_valid)
        msu_irq == $past(|(msu_stat_w & msu_en_w))); // R6

    AST_GRP_EN_HOLD: assert property (@(posedge clk) disable iff (rst || !past_valid)
        !$past(wr_en && wr_addr == OFF_GRP_EN) |-> $stable(grp_irq_en)); // R2

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst || !past_valid)
        !$past(wr_en && (wr_addr == OFF_RESP || wr_addr == OFF_CALL))
            |-> ($stable(resp_cfg) && $stable(call_cfg))); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst_d |-> (grp_irq_en == '0 && grp_irq_clr == '0 && msu_clr == '0
                   && !msu_irq && !resp_cfg && call_cfg == 2'b00)); // R12
endmodule

bind sec_irq_agg sec_irq_agg_chk #(.N_MSU(N_MSU)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .grp_irq_en  (grp_irq_en),
    .grp_irq_clr (grp_irq_clr),
    .msu_clr     (msu_clr),
    .msu_irq     (msu_irq),
    .resp_cfg    (resp_cfg),
    .call_cfg    (call_cfg),
    .msu_stat_w  (msu_stat_w),
    .msu_en_w    (msu_en_w)
);

// File: tb/sim_sec_irq_agg.sv
module sim_sec_irq_agg;

    localparam int NG = 10;
    localparam int NMI = 1;
    localparam int NME = 16;
    localparam int NMS = 4;
    localparam int POS [NG] = '{0, 1, 4, 5, 6, 7, 20, 21, 22, 23};
    localparam logic [7:0] ADDRS [14] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                                          8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h3C};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [7:0]     wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [7:0]     rd_addr = '0;
    logic [31:0]    rd_data;
    logic [NG-1:0]  grp_status = '0;
    logic [NMI-1:0] mpu_int_status = '0;
    logic [NME-1:0] mpu_exp_status = '0;
    logic [NMS-1:0] msu_status = '0;
    logic [NG-1:0]  grp_irq_en, grp_irq_clr;
    logic [NMS-1:0] msu_clr, msu_ns;
    logic           msu_irq, resp_cfg;
    logic [1:0]     call_cfg;

    sec_irq_agg u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .grp_status(grp_status),
        .mpu_int_status(mpu_int_status), .mpu_exp_status(mpu_exp_status),
        .msu_status(msu_status), .grp_irq_en(grp_irq_en), .grp_irq_clr(grp_irq_clr),
        .msu_clr(msu_clr), .msu_ns(msu_ns), .msu_irq(msu_irq),
        .resp_cfg(resp_cfg), .call_cfg(call_cfg)
    );

    int n_vec = 0;
    int n_bad = 0;

    // behavioural reference state
    logic        m_resp;
    logic [1:0]  m_call;
    logic [31:0] m_gen, m_gclr, m_men, m_mclr, m_mns, m_brg;
    logic [31:0] m_gstat, m_mpu, m_mstat;
    logic        m_irq;

    function automatic logic [31:0] spread_grp(input logic [NG-1:0] v);
        logic [31:0] w = '0;
        for (int i = 0; i < NG; i++) w[POS[i]] = v[i];
        return w;
    endfunction

    function automatic logic [NG-1:0] gather_grp(input logic [31:0] w);
        logic [NG-1:0] v;
        for (int i = 0; i < NG; i++) v[i] = w[POS[i]];
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_resp <= 0; m_call <= 0; m_gen <= 0; m_gclr <= 0; m_men <= 0;
            m_mclr <= 0; m_mns <= 0; m_brg <= 0; m_gstat <= 0; m_mpu <= 0;
            m_mstat <= 0; m_irq <= 0;
        end else begin
            m_gstat <= spread_grp(grp_status);
            m_mpu   <= {mpu_exp_status, 15'd0, mpu_int_status};
            m_mstat <= {12'd0, msu_status, 16'd0};
            m_irq   <= (m_mstat & m_men) != 0;
            m_gclr  <= 0;
            m_mclr  <= 0;
            if (wr_en) begin
                case (wr_addr)
                    8'h00: m_resp <= wr_data[0];
                    8'h04: m_call <= wr_data[1:0];
                    8'h10: m_gclr <= wr_data & 32'h00F0_00F3;
                    8'h14: m_gen  <= wr_data & 32'h00F0_00F3;
                    8'h1C: m_mclr <= wr_data & 32'h000F_0000;
                    8'h20: m_men  <= wr_data & 32'h000F_0000;
                    8'h2C: m_brg  <= wr_data & 32'hFFFF_0000;
                    8'h30: m_mns  <= wr_data & 32'h000F_0000;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return {31'd0, m_resp};
            8'h04: return {30'd0, m_call};
            8'h08: return m_mpu;
            8'h0C: return m_gstat;
            8'h14: return m_gen;
            8'h18: return m_mstat;
            8'h20: return m_men;
            8'h2C: return m_brg;
            8'h30: return m_mns;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        case (a)
            8'h00, 8'h04: return "R9 config readback";
            8'h08: return "R4 mpu status";
            8'h0C: return "R1 group status";
            8'h10: return "R3 group clear reads zero";
            8'h14: return "R2 group enable";
            8'h18: return "R5 master status";
            8'h1C: return "R7 master clear reads zero";
            8'h20: return "R5 master enable";
            8'h24, 8'h28, 8'h2C: return "R10 bridge word";
            8'h30: return "R8 master non-secure";
            default: return "R11 unmapped reads zero";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // compare every port against the model each clock, away from the edge
    always @(posedge clk) begin
        #5;
        chk(rd_tag(rd_addr), rd_data, exp_rd(rd_addr));
        chk("R2 grp_irq_en", 32'(grp_irq_en), 32'(gather_grp(m_gen)));
        chk("R3 grp_irq_clr", 32'(grp_irq_clr), 32'(gather_grp(m_gclr)));
        chk("R7 msu_clr", 32'(msu_clr), 32'(m_mclr[19:16]));
        chk("R8 msu_ns", 32'(msu_ns), 32'(m_mns[19:16]));
        chk("R6 msu_irq", 32'(msu_irq), 32'(m_irq));
        chk("R9 resp_cfg", 32'(resp_cfg), 32'(m_resp));
        chk("R9 call_cfg", 32'(call_cfg), 32'(m_call));
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sweep();
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            rd_addr = ADDRS[i];
        end
    endtask

    task automatic reset_check();
        @(negedge clk);
        chk("R12 reset grp_irq_en", 32'(grp_irq_en), 32'd0);
        chk("R12 reset strobes", 32'({grp_irq_clr, msu_clr}), 32'd0);
        chk("R12 reset msu_ns/irq", 32'({msu_ns, msu_irq}), 32'd0);
        chk("R12 reset cfg", 32'({resp_cfg, call_cfg}), 32'd0);
        for (int i = 0; i < 14; i++) begin
            rd_addr = ADDRS[i];
            #1;
            chk("R12 reset readback", rd_data, 32'd0);
        end
    endtask

    task automatic random_phase(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            grp_status     = NG'($urandom);
            mpu_int_status = NMI'($urandom);
            mpu_exp_status = NME'($urandom);
            msu_status     = NMS'($urandom);
            wr_en          = $urandom_range(0, 1) == 1;
            wr_addr        = ADDRS[$urandom_range(0, 13)];
            wr_data        = $urandom;
            rd_addr        = ADDRS[$urandom_range(0, 13)];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        // R12: reset with busy inputs
        grp_status = '1; mpu_int_status = '1; mpu_exp_status = '1; msu_status = '1;
        wr_en = 1'b1; wr_addr = 8'h14; wr_data = '1;
        repeat (3) @(negedge clk);
        reset_check();
        wr_en = 1'b0;
        grp_status = '0; mpu_int_status = '0; mpu_exp_status = '0; msu_status = '0;
        @(negedge clk);
        rst = 1'b0;
        sweep();

        // all-ones to each writable word, then read all words (R2 R5 R8 R9 R10)
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        sweep();

        // R1: walk each group input
        for (int i = 0; i < NG; i++) begin
            @(negedge clk);
            rd_addr = 8'h0C;
            grp_status = NG'(1) << i;
            repeat (2) @(negedge clk);
        end
        grp_status = '0;

        // R4: walk memory-protection inputs
        @(negedge clk);
        rd_addr = 8'h08;
        mpu_int_status = '1;
        repeat (2) @(negedge clk);
        mpu_int_status = '0;
        for (int i = 0; i < NME; i++) begin
            @(negedge clk);
            mpu_exp_status = NME'(1) << i;
        end
        mpu_exp_status = '0;

        // R5 R6: master status with enable on, then enable off
        for (int i = 0; i < NMS; i++) begin
            @(negedge clk);
            rd_addr = 8'h18;
            msu_status = NMS'(1) << i;
            repeat (3) @(negedge clk);
            msu_status = '0;
            repeat (2) @(negedge clk);
        end
        wr(8'h20, 32'h0004_0000);
        msu_status = 4'b1011;
        repeat (4) @(negedge clk);
        msu_status = 4'b0100;
        repeat (4) @(negedge clk);
        wr(8'h20, 32'h0000_FFFF);
        repeat (3) @(negedge clk);
        msu_status = '0;

        // R3 R7: clears, including back-to-back writes
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h10, 32'h0010_0002);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h1C; wr_data = 32'h000A_0000;
        @(negedge clk);
        wr_data = 32'h0005_0000;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);

        // R10 R11: writes to read-only, bridge and unmapped words
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        sweep();

        random_phase(3000);

        // R12: reset in the middle of activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        reset_check();
        @(negedge clk);
        rst = 1'b0;
        random_phase(800);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, all requirements affected");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule